// File: doc/BRIEF.md
# Run-Length Sample Compressor

This block sits between the sampling front end of a logic analyzer and its capture memory. It squeezes out runs of identical samples. Each sample is 8, 16 or 32 bits wide, chosen by a mode input. The top bit of the selected width is given up as a flag. A word with the flag clear carries a literal sample. A word with the flag set carries a repeat count for the literal before it. So a run of identical samples costs two memory words however long it lasts. A single sample costs one word.

Words leave on a registered output, at most one per clock. When a run ends on a new sample, the count word and the new literal are both due in the same cycle. The count goes first and the literal is held for one cycle in a one-word holding register. A flush input closes the current run, so the pending count is written before capture stops. With enable low, the block is a plain registered pipe: samples pass through at the selected width, nothing is compressed, and the marker channel is ordinary data.

Top module: `rle_compressor`

## Requirements
- R1: The mode input selects the word width W: code 00 gives 8 bits, 01 gives 16 bits, 10 and 11 give 32 bits. Every output word sits in bits W-1:0, and all bits above W-1 are zero.
- R2: A literal word has the marker (bit W-1) at 0. Its bits W-2:0 equal the sample's bits W-2:0.
- R3: Two samples are treated as identical when bits W-2:0 match. Bit W-1 and the bits above it never affect run detection.
- R4: A run of L identical samples, with L of two or more, produces the literal for its first sample and, when the run ends, one count word. The count word has bit W-1 at 1 and holds L-1 in bits W-2:0. A different sample ends the run and also emits its own literal.
- R5: A run of one sample produces no count word.
- R6: When the repeat count reaches 2^(W-1)-1, the count word (all W bits set) is emitted for that sample. The next identical sample then starts a new run with a fresh literal.
- R7: flush_i closes the current run after any sample given in the same cycle has been handled. A nonzero pending count is emitted, and the next sample is treated as the first of a new run.
- R8: At most one word leaves per clock. When two words are due at once, the order is: the held word, then a count that ends the old run, then the new literal, then a count raised by saturation or flush. A displaced word appears in the very next cycle.
- R9: With nothing held, a word appears on the output one clock after the input that caused it. A cycle in which nothing is due shows word_valid_o low.
- R10: With en_i low, word_valid_o follows smp_valid_i one clock later, and word_data_o carries the sample's low W bits unchanged, marker bit included. No count words are produced. Any pending run and any held word are dropped, and re-enabling starts from an empty run.
- R11: While rst_ni is low, word_valid_o and word_data_o are 0. Reset discards any run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1 = compress, 0 = pass samples through |
| mode_i | input | 2 | Word width: 00 = 8, 01 = 16, 1x = 32 |
| flush_i | input | 1 | Close the current run and emit its count |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DATA_W | Sample word |
| word_valid_o | output | 1 | Memory word strobe |
| word_data_o | output | DATA_W | Memory word, low W bits used |

## Verification
The collision that matters is a count word that ends a run meeting the literal of the next sample. It is provoked by a short run followed by a new value. The bench expects the count first and the literal on the following clock, even when the input goes idle. A harder case adds a flush and a repeat on the very cycle a literal is still held: three words are then queued across two cycles. The bench checks that the held literal, then the flush count, come out on consecutive clocks with no gap and no loss. Saturation is covered by driving exactly 2^(W-1)+1 equal samples in 8-bit and 16-bit mode and checking where the all-ones count word lands.

// File: rtl/rle_pkg.sv
`timescale 1ns/1ps
package rle_pkg;
  typedef enum logic [1:0] {
    WMODE_8   = 2'b00,
    WMODE_16  = 2'b01,
    WMODE_32  = 2'b10,
    WMODE_32B = 2'b11
  } wmode_e;

  // output slot order, lowest index leaves first
  localparam int unsigned N_SLOTS   = 4;
  localparam int unsigned SLOT_HELD = 0;
  localparam int unsigned SLOT_PRE  = 1;
  localparam int unsigned SLOT_LIT  = 2;
  localparam int unsigned SLOT_POST = 3;
endpackage

// File: rtl/rle_width_ctl.sv
`timescale 1ns/1ps
module rle_width_ctl
  import rle_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] word_mask_o,
  output logic [DATA_W-1:0] body_mask_o,
  output logic [DATA_W-1:0] marker_o
);
  localparam logic [DATA_W-1:0] ALL1   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] MASK_Q = ALL1 >> (DATA_W - DATA_W/4);
  localparam logic [DATA_W-1:0] MASK_H = ALL1 >> (DATA_W - DATA_W/2);

  always_comb begin
    case (wmode_e'(mode_i))
      WMODE_8:  word_mask_o = MASK_Q;
      WMODE_16: word_mask_o = MASK_H;
      default:  word_mask_o = ALL1;
    endcase
  end

  assign body_mask_o = word_mask_o >> 1;
  assign marker_o    = word_mask_o ^ body_mask_o;
endmodule

// File: rtl/rle_run_tracker.sv
`timescale 1ns/1ps
module rle_run_tracker #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic              flush_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] body_mask_i,
  input  logic [DATA_W-1:0] marker_i,
  output logic              pre_vld_o,
  output logic [DATA_W-1:0] pre_word_o,
  output logic              lit_vld_o,
  output logic [DATA_W-1:0] lit_word_o,
  output logic              post_vld_o,
  output logic [DATA_W-1:0] post_word_o,
  output logic              have_run_o,
  output logic [DATA_W-1:0] cnt_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              have_q, have_d;
  logic [DATA_W-1:0] ref_q, ref_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] body, cnt_inc;
  logic              match;

  assign body    = sample_i & body_mask_i;
  assign match   = have_q && (body == (ref_q & body_mask_i));
  assign cnt_inc = cnt_q + ONE;

  always_comb begin
    have_d      = have_q;
    ref_d       = ref_q;
    cnt_d       = cnt_q;
    pre_vld_o   = 1'b0;
    pre_word_o  = '0;
    lit_vld_o   = 1'b0;
    lit_word_o  = '0;
    post_vld_o  = 1'b0;
    post_word_o = '0;
    if (!en_i) begin
      have_d = 1'b0;
      cnt_d  = '0;
    end else begin
      if (valid_i) begin
        if (match) begin
          if (cnt_inc == body_mask_i) begin
            // saturated: close pair, next equal sample reopens
            post_vld_o  = 1'b1;
            post_word_o = marker_i | cnt_inc;
            have_d      = 1'b0;
            cnt_d       = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end else begin
          if (cnt_q != '0) begin
            pre_vld_o  = 1'b1;
            pre_word_o = marker_i | cnt_q;
          end
          lit_vld_o  = 1'b1;
          lit_word_o = body;
          have_d     = 1'b1;
          ref_d      = body;
          cnt_d      = '0;
        end
      end
      if (flush_i) begin
        if (!post_vld_o && cnt_d != '0) begin
          post_vld_o  = 1'b1;
          post_word_o = marker_i | cnt_d;
        end
        have_d = 1'b0;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      ref_q  <= '0;
      cnt_q  <= '0;
    end else begin
      have_q <= have_d;
      ref_q  <= ref_d;
      cnt_q  <= cnt_d;
    end
  end

  assign have_run_o = have_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/rle_out_queue.sv
`timescale 1ns/1ps
module rle_out_queue
  import rle_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pass_vld_i,
  input  logic [DATA_W-1:0] pass_word_i,
  input  logic              pre_vld_i,
  input  logic [DATA_W-1:0] pre_word_i,
  input  logic              lit_vld_i,
  input  logic [DATA_W-1:0] lit_word_i,
  input  logic              post_vld_i,
  input  logic [DATA_W-1:0] post_word_i,
  output logic              held_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              held_q;
  logic [DATA_W-1:0] held_w_q;
  logic [N_SLOTS-1:0] req;
  logic [DATA_W-1:0] cand [N_SLOTS];
  logic              first_vld, second_vld;
  logic [DATA_W-1:0] first_w, second_w;

  always_comb begin
    req             = '0;
    req[SLOT_HELD]  = held_q;
    req[SLOT_PRE]   = pre_vld_i;
    req[SLOT_LIT]   = lit_vld_i;
    req[SLOT_POST]  = post_vld_i;
    cand[SLOT_HELD] = held_w_q;
    cand[SLOT_PRE]  = pre_word_i;
    cand[SLOT_LIT]  = lit_word_i;
    cand[SLOT_POST] = post_word_i;
  end

  always_comb begin
    first_vld  = 1'b0;
    second_vld = 1'b0;
    first_w    = '0;
    second_w   = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (req[i]) begin
        if (!first_vld) begin
          first_vld = 1'b1;
          first_w   = cand[i];
        end else if (!second_vld) begin
          second_vld = 1'b1;
          second_w   = cand[i];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      data_o   <= '0;
      held_q   <= 1'b0;
      held_w_q <= '0;
    end else if (!en_i) begin
      valid_o  <= pass_vld_i;
      data_o   <= pass_vld_i ? pass_word_i : '0;
      held_q   <= 1'b0;
      held_w_q <= '0;
    end else begin
      valid_o  <= first_vld;
      data_o   <= first_w;
      held_q   <= second_vld;
      held_w_q <= second_w;
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/rle_compressor.sv
`timescale 1ns/1ps
module rle_compressor #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic              flush_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic              word_valid_o,
  output logic [DATA_W-1:0] word_data_o
);
  logic [DATA_W-1:0] word_mask, body_mask, marker;
  logic              pre_vld, lit_vld, post_vld;
  logic [DATA_W-1:0] pre_word, lit_word, post_word;
  logic              have_run, held_full;
  logic [DATA_W-1:0] run_cnt;

  rle_width_ctl #(.DATA_W(DATA_W)) u_width (
    .mode_i      (mode_i),
    .word_mask_o (word_mask),
    .body_mask_o (body_mask),
    .marker_o    (marker)
  );

  rle_run_tracker #(.DATA_W(DATA_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .valid_i     (smp_valid_i),
    .flush_i     (flush_i),
    .sample_i    (smp_data_i),
    .body_mask_i (body_mask),
    .marker_i    (marker),
    .pre_vld_o   (pre_vld),
    .pre_word_o  (pre_word),
    .lit_vld_o   (lit_vld),
    .lit_word_o  (lit_word),
    .post_vld_o  (post_vld),
    .post_word_o (post_word),
    .have_run_o  (have_run),
    .cnt_o       (run_cnt)
  );

  rle_out_queue #(.DATA_W(DATA_W)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .pass_vld_i  (smp_valid_i),
    .pass_word_i (smp_data_i & word_mask),
    .pre_vld_i   (pre_vld),
    .pre_word_i  (pre_word),
    .lit_vld_i   (lit_vld),
    .lit_word_i  (lit_word),
    .post_vld_i  (post_vld),
    .post_word_i (post_word),
    .held_o      (held_full),
    .valid_o     (word_valid_o),
    .data_o      (word_data_o)
  );
endmodule

// File: rtl/rle_compressor_chk.sv
`timescale 1ns/1ps
module rle_compressor_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              valid_i,
  input logic              flush_i,
  input logic              valid_o,
  input logic              held_i,
  input logic              pre_vld_i,
  input logic              lit_vld_i,
  input logic              post_vld_i,
  input logic              have_run_i,
  input logic [DATA_W-1:0] cnt_i
);
  // R10
  pass_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (valid_o == $past(valid_i)));

  // R8
  two_words_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> ($countones({held_i, pre_vld_i, lit_vld_i, post_vld_i}) <= 2));

  // R8
  held_drains_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_i && en_i) |=> valid_o);

  // R9
  fresh_literal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && !have_run_i && !held_i) |=> valid_o);

  // R7
  flush_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && flush_i) |=> (!have_run_i && cnt_i == '0));
endmodule

bind rle_compressor rle_compressor_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .valid_i    (smp_valid_i),
  .flush_i    (flush_i),
  .valid_o    (word_valid_o),
  .held_i     (held_full),
  .pre_vld_i  (pre_vld),
  .lit_vld_i  (lit_vld),
  .post_vld_i (post_vld),
  .have_run_i (have_run),
  .cnt_i      (run_cnt)
);

// File: tb/rle_compressor_tb.sv
`timescale 1ns/1ps
module rle_compressor_tb;
  localparam int unsigned DW = 32;
  localparam int unsigned NV = 35;

  typedef struct packed {
    logic        en;
    logic [1:0]  mode;
    logic        vld;
    logic        fl;
    logic [31:0] smp;
    logic        ev;
    logic [31:0] ed;
    logic [7:0]  req;
  } vec_t;

  // expected word is the output one clock after the row is applied
  localparam vec_t TAB [NV] = '{
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h12,       1'b1, 32'h12,       8'd2},  // R2
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h12,       1'b0, 32'h0,        8'd4},  // R4
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h12,       1'b0, 32'h0,        8'd4},
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h34,       1'b1, 32'h82,       8'd4},
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h56,       1'b1, 32'h34,       8'd8},  // R8
    '{1'b1, 2'd0, 1'b0, 1'b0, 32'h0,        1'b1, 32'h56,       8'd8},
    '{1'b1, 2'd0, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0,        8'd9},  // R9
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h9A,       1'b1, 32'h1A,       8'd2},
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h1A,       1'b0, 32'h0,        8'd3},  // R3
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'hF9A,      1'b0, 32'h0,        8'd3},
    '{1'b1, 2'd0, 1'b0, 1'b1, 32'h0,        1'b1, 32'h82,       8'd7},  // R7
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h1A,       1'b1, 32'h1A,       8'd7},
    '{1'b1, 2'd0, 1'b1, 1'b1, 32'h1A,       1'b1, 32'h81,       8'd7},
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h1A,       1'b1, 32'h1A,       8'd7},
    '{1'b1, 2'd0, 1'b1, 1'b1, 32'h20,       1'b1, 32'h20,       8'd5},  // R5
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h20,       1'b1, 32'h20,       8'd7},
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h20,       1'b0, 32'h0,        8'd4},
    '{1'b0, 2'd0, 1'b1, 1'b0, 32'hA5,       1'b1, 32'hA5,       8'd10}, // R10
    '{1'b0, 2'd0, 1'b1, 1'b0, 32'h3A5,      1'b1, 32'hA5,       8'd10},
    '{1'b0, 2'd0, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0,        8'd10},
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'hA5,       1'b1, 32'h25,       8'd10},
    '{1'b1, 2'd1, 1'b1, 1'b0, 32'h1234,     1'b1, 32'h1234,     8'd1},  // R1
    '{1'b1, 2'd1, 1'b1, 1'b0, 32'hABCD1234, 1'b0, 32'h0,        8'd1},
    '{1'b1, 2'd1, 1'b1, 1'b0, 32'hFFFF,     1'b1, 32'h8001,     8'd4},
    '{1'b1, 2'd1, 1'b0, 1'b0, 32'h0,        1'b1, 32'h7FFF,     8'd2},
    '{1'b1, 2'd2, 1'b1, 1'b0, 32'h80000001, 1'b1, 32'h1,        8'd1},
    '{1'b1, 2'd2, 1'b1, 1'b0, 32'h1,        1'b0, 32'h0,        8'd4},
    '{1'b1, 2'd2, 1'b1, 1'b1, 32'h1,        1'b1, 32'h80000002, 8'd7},
    '{1'b1, 2'd2, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0,        8'd7},
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h11,       1'b1, 32'h11,       8'd2},
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h11,       1'b0, 32'h0,        8'd4},
    '{1'b1, 2'd0, 1'b1, 1'b0, 32'h22,       1'b1, 32'h81,       8'd8},
    '{1'b1, 2'd0, 1'b1, 1'b1, 32'h22,       1'b1, 32'h22,       8'd8},
    '{1'b1, 2'd0, 1'b0, 1'b0, 32'h0,        1'b1, 32'h81,       8'd8},
    '{1'b1, 2'd0, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0,        8'd8}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          flush = 1'b0;
  logic          svld = 1'b0;
  logic [DW-1:0] sdat = '0;
  logic          wvld;
  logic [DW-1:0] wdat;
  int            total = 0;
  int            bad = 0;

  always #2.5 clk = ~clk;

  rle_compressor #(.DATA_W(DW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .mode_i       (mode),
    .flush_i      (flush),
    .smp_valid_i  (svld),
    .smp_data_i   (sdat),
    .word_valid_o (wvld),
    .word_data_o  (wdat)
  );

  task automatic check(input string tag, input logic ev, input logic [DW-1:0] ed);
    total++;
    if (wvld !== ev || (ev && wdat !== ed)) begin
      bad++;
      $display("FAIL %s: got vld=%0b data=%h, want vld=%0b data=%h", tag, wvld, wdat, ev, ed);
    end
  endtask

  // drive at a falling edge, return at the next one with the output settled
  task automatic apply(input logic e, input logic [1:0] m, input logic v,
                       input logic f, input logic [DW-1:0] d);
    en = e; mode = m; svld = v; flush = f; sdat = d;
    @(negedge clk);
  endtask

  task automatic saturate(input logic [1:0] m, input int unsigned w, input logic [DW-1:0] val,
                          input string tag);
    int unsigned n;
    int          errs;
    logic [DW-1:0] ones;
    n    = 1 << (w - 1);
    ones = (w == 32) ? '1 : ((DW'(1) << w) - 1);
    errs = 0;
    for (int unsigned i = 0; i <= n; i++) begin
      apply(1'b1, m, 1'b1, 1'b0, val);
      if (i == 0 || i == n) begin
        if (wvld !== 1'b1 || wdat !== val) errs++;
      end else if (i == n - 1) begin
        if (wvld !== 1'b1 || wdat !== ones) errs++;
      end else if (wvld !== 1'b0) begin
        errs++;
      end
    end
    total++;
    if (errs != 0) begin
      bad++;
      $display("FAIL %s: %0d wrong cycles in saturation run, want count word %h", tag, errs, ones);
    end
    apply(1'b1, m, 1'b0, 1'b1, '0);
    check(tag, 1'b0, '0);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: run did not finish, want completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", 1'b0, '0);
    total++;
    if (wdat !== '0) begin
      bad++;
      $display("FAIL R11: data=%h, want 0", wdat);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      apply(TAB[k].en, TAB[k].mode, TAB[k].vld, TAB[k].fl, TAB[k].smp);
      check($sformatf("R%0d row%0d", TAB[k].req, k), TAB[k].ev, TAB[k].ed);
    end

    // R6 in 8-bit and 16-bit mode
    saturate(2'd0, 8, 32'h33, "R6 w8");
    saturate(2'd1, 16, 32'h0ABC, "R6 w16");

    // R11 reset during a run discards it
    apply(1'b1, 2'd0, 1'b1, 1'b0, 32'h44);
    check("R11 pre", 1'b1, 32'h44);
    apply(1'b1, 2'd0, 1'b1, 1'b0, 32'h44);
    check("R11 pre", 1'b0, '0);
    svld  = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 mid", 1'b0, '0);
    rst_n = 1'b1;
    apply(1'b1, 2'd0, 1'b1, 1'b0, 32'h44);
    check("R11 post", 1'b1, 32'h44);
    apply(1'b1, 2'd0, 1'b0, 1'b1, '0);
    check("R11 post", 1'b0, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule